// File: doc/BRIEF.md
# Four-Bank DRAM Command Timing Guard

This block sits between a DRAM controller's command scheduler and the memory pins. It keeps the timing state of every bank: whether a row is open, and how many clocks remain on each bank's delays. It also keeps the delays that span banks: the spacing between row openings, the turnaround from write to read, and the refresh busy time. From that state it tells the scheduler, in every cycle and for every bank, which command kinds may be issued now. When the scheduler issues a command, the block updates its counters in the same clock edge.

All delays are parameters counted in controller clocks. The defaults assume a 5 ns clock. The scheduler picks commands and maps addresses, and the data path lies elsewhere; this block only judges and records.

For READ and WRITE, address bit 10 requests a deferred close of the row. The bank then accepts no further access and closes by itself once its minimum row-active time and any write recovery have both run out. Each bank also counts how long its row has been open. A warning output rises when any bank nears the maximum row-open time.

Top module: `dtc_timing_checker`

## Requirements
- R1: Command codes on `cmd_kind` are 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE and 5 REFRESH; every other code is no command. After reset all banks are closed. `act_ok_o` is all ones. `rd_ok_o`, `wr_ok_o` and `pre_ok_o` are zero. `pre_all_ok_o` and `ref_ok_o` are one, and `row_warn_o` is zero.
- R2: After an ACTIVATE issued at edge n, READ and WRITE to that bank are first allowed at edge n+T_RCD.
- R3: PRECHARGE of a single bank is allowed only while that bank is open, and no earlier than T_RAS clocks after its ACTIVATE.
- R4: After a PRECHARGE at edge n, ACTIVATE of that bank is first allowed at edge n+T_RP. ACTIVATE of the same bank also waits T_RC clocks after its previous ACTIVATE.
- R5: After an ACTIVATE at edge n, ACTIVATE of any other bank is first allowed at edge n+T_RRD.
- R6: After a WRITE at edge n, PRECHARGE of that bank is held off until edge n+T_WDATA+T_WR.
- R7: After a WRITE at edge n, READ on every bank is held off until edge n+T_WDATA+T_WTR.
- R8: A READ or WRITE with `cmd_a10` high sets a pending close on its bank. While the close is pending, READ, WRITE and PRECHARGE to that bank are refused. The bank closes at the first edge at which both its T_RAS window and its write recovery have expired. T_RP then applies as after an explicit PRECHARGE.
- R9: PRECHARGE with `cmd_a10` low closes only the bank on `cmd_bank`. With `cmd_a10` high it closes every bank and ignores `cmd_bank`. It is then allowed (`pre_all_ok_o`) only when every open bank would accept a single PRECHARGE and no close is pending.
- R10: REFRESH is allowed only when all banks are closed and past T_RP and T_RC. After a REFRESH at edge n, REFRESH and ACTIVATE are first allowed at edge n+T_RFC.
- R11: A command issued while its legal flag is low is ignored and changes no state.
- R12: `row_warn_o` is high while any bank has been open for T_RAS_MAX-ROW_WARN_MARGIN clocks or more. It falls when that bank closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_issue | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | Command code (see R1) |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| cmd_a10 | input | 1 | Auto-close for READ/WRITE, all-bank select for PRECHARGE |
| act_ok_o | output | NUM_BANKS | ACTIVATE allowed, per bank |
| rd_ok_o | output | NUM_BANKS | READ allowed, per bank |
| wr_ok_o | output | NUM_BANKS | WRITE allowed, per bank |
| pre_ok_o | output | NUM_BANKS | Single-bank PRECHARGE allowed, per bank |
| pre_all_ok_o | output | 1 | All-bank PRECHARGE allowed |
| ref_ok_o | output | 1 | REFRESH allowed |
| bank_open_o | output | NUM_BANKS | Row open, per bank |
| row_warn_o | output | 1 | Some bank is near its maximum open time |

## Verification
The bench keeps the default delays for a 5 ns clock, so every legal-flag edge is checked at the exact clock the defaults give. Write recovery ending after the row-active minimum makes a write with auto-close close two clocks later than a read with auto-close. The bench lowers T_RAS_MAX to 40 and ROW_WARN_MARGIN to 8, so the row-age warning crosses its threshold after 32 clocks instead of thousands.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5
  } cmd_e;
endpackage

// File: rtl/dtc_dcount.sv
// Down-counter that reloads a fixed value and reports when it has run out.
module dtc_dcount #(
  parameter int unsigned LOADV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);
  localparam int unsigned W = (LOADV < 1) ? 1 : $clog2(LOADV + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = W'(LOADV);
    else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dtc_bank.sv
// Timing state of one bank: open row, per-bank delays, pending close, row age.
module dtc_bank #(
  parameter int unsigned T_RCD     = 4,
  parameter int unsigned T_RAS     = 8,
  parameter int unsigned T_RC      = 12,
  parameter int unsigned T_RP      = 4,
  parameter int unsigned T_WREC    = 6,
  parameter int unsigned T_RAS_MAX = 14000,
  parameter int unsigned WARN_AT   = 13800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_fire_i,
  input  logic rd_fire_i,
  input  logic wr_fire_i,
  input  logic pre_fire_i,
  input  logic auto_close_req_i,
  output logic open_o,
  output logic act_ready_o,
  output logic rw_ready_o,
  output logic pre_ready_o,
  output logic all_ready_o,
  output logic warn_o
);
  localparam int unsigned AW = $clog2(T_RAS_MAX + 1);

  logic rcd_zero, ras_zero, rc_zero, rp_zero, wrec_zero;
  logic open_q, open_d, ap_q, ap_d;
  logic auto_close, rp_load;
  logic [AW-1:0] age_q, age_d;
  logic age_en;

  assign auto_close = ap_q && ras_zero && wrec_zero;
  assign rp_load    = pre_fire_i || auto_close;

  dtc_dcount #(.LOADV(T_RCD - 1)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load_i(act_fire_i), .zero_o(rcd_zero));
  dtc_dcount #(.LOADV(T_RAS - 1)) u_ras (
    .clk(clk), .rst_n(rst_n), .load_i(act_fire_i), .zero_o(ras_zero));
  dtc_dcount #(.LOADV(T_RC - 1)) u_rc (
    .clk(clk), .rst_n(rst_n), .load_i(act_fire_i), .zero_o(rc_zero));
  dtc_dcount #(.LOADV(T_RP - 1)) u_rp (
    .clk(clk), .rst_n(rst_n), .load_i(rp_load), .zero_o(rp_zero));
  dtc_dcount #(.LOADV(T_WREC - 1)) u_wrec (
    .clk(clk), .rst_n(rst_n), .load_i(wr_fire_i), .zero_o(wrec_zero));

  always_comb begin
    open_d = open_q;
    ap_d   = ap_q;
    if (act_fire_i) open_d = 1'b1;
    if (pre_fire_i || auto_close) open_d = 1'b0;
    if ((rd_fire_i || wr_fire_i) && auto_close_req_i) ap_d = 1'b1;
    if (auto_close) ap_d = 1'b0;
  end

  assign age_en = act_fire_i || (open_q && (age_q != AW'(T_RAS_MAX)));

  always_comb begin
    age_d = age_q;
    if (act_fire_i) age_d = '0;
    else if (open_q && (age_q != AW'(T_RAS_MAX))) age_d = age_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
    end else begin
      open_q <= open_d;
      ap_q   <= ap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_en) age_q <= age_d;
  end

  assign open_o      = open_q;
  assign act_ready_o = !open_q && rp_zero && rc_zero;
  assign rw_ready_o  = open_q && rcd_zero && !ap_q;
  assign pre_ready_o = open_q && ras_zero && wrec_zero && !ap_q;
  assign all_ready_o = !ap_q && (!open_q || (ras_zero && wrec_zero));
  assign warn_o      = open_q && (age_q >= AW'(WARN_AT));

  // R2: no access in the clock right after the row opens
  p_rcd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fire_i && T_RCD > 1) |=> !rw_ready_o);
  // R3: a row only closes once its row-active minimum has run out
  p_close_after_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> $past(ras_zero));
  // R8: a pending close is only ever set on an open bank
  p_ap_on_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ap_q) |-> open_q);
endmodule

// File: rtl/dtc_global.sv
// Delays that span banks: row-open spacing, write-to-read turnaround, refresh busy.
module dtc_global #(
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_WTR_TOT = 5,
  parameter int unsigned T_RFC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_any_i,
  input  logic wr_any_i,
  input  logic ref_fire_i,
  output logic rrd_zero_o,
  output logic wtr_zero_o,
  output logic rfc_zero_o
);
  dtc_dcount #(.LOADV(T_RRD - 1)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load_i(act_any_i), .zero_o(rrd_zero_o));
  dtc_dcount #(.LOADV(T_WTR_TOT - 1)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load_i(wr_any_i), .zero_o(wtr_zero_o));
  dtc_dcount #(.LOADV(T_RFC - 1)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load_i(ref_fire_i), .zero_o(rfc_zero_o));

  // R10: refresh busy time starts in the clock after REFRESH
  p_rfc_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fire_i && T_RFC > 1) |=> !rfc_zero_o);
  // R7: reads are held off right after a write
  p_wtr_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any_i && T_WTR_TOT > 1) |=> !wtr_zero_o);
endmodule

// File: rtl/dtc_timing_checker.sv
// Command legality guard for a multi-bank DRAM. Delays in clocks (5 ns defaults).
module dtc_timing_checker #(
  parameter int unsigned NUM_BANKS       = 4,
  parameter int unsigned T_RCD           = 4,     // 20 ns
  parameter int unsigned T_RAS           = 8,     // 40 ns
  parameter int unsigned T_RC            = 12,    // 60 ns
  parameter int unsigned T_RP            = 4,     // 20 ns
  parameter int unsigned T_RRD           = 2,     // 10 ns
  parameter int unsigned T_WDATA         = 3,     // write command to last data
  parameter int unsigned T_WR            = 3,     // 15 ns
  parameter int unsigned T_WTR           = 2,
  parameter int unsigned T_RFC           = 14,    // 70 ns
  parameter int unsigned T_RAS_MAX       = 14000, // 70 us
  parameter int unsigned ROW_WARN_MARGIN = 200,
  localparam int unsigned BW = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_issue,
  input  logic [2:0]           cmd_kind,
  input  logic [BW-1:0]        cmd_bank,
  input  logic                 cmd_a10,
  output logic [NUM_BANKS-1:0] act_ok_o,
  output logic [NUM_BANKS-1:0] rd_ok_o,
  output logic [NUM_BANKS-1:0] wr_ok_o,
  output logic [NUM_BANKS-1:0] pre_ok_o,
  output logic                 pre_all_ok_o,
  output logic                 ref_ok_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 row_warn_o
);
  import dtc_pkg::*;

  localparam int unsigned WARN_AT   = T_RAS_MAX - ROW_WARN_MARGIN;
  localparam int unsigned T_WREC    = T_WDATA + T_WR;
  localparam int unsigned T_WTR_TOT = T_WDATA + T_WTR;

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cmd_e kind;
  logic [NUM_BANKS-1:0] sel;
  logic [NUM_BANKS-1:0] act_fire, rd_fire, wr_fire, pre_fire;
  logic [NUM_BANKS-1:0] act_ready, rw_ready, pre_ready, all_ready, warn;
  logic rrd_zero, wtr_zero, rfc_zero;
  logic legal, accept, ref_fire;

  assign kind = cmd_e'(cmd_kind);
  assign sel  = NUM_BANKS'(1) << cmd_bank;

  assign act_ok_o     = act_ready & {NUM_BANKS{rrd_zero && rfc_zero}};
  assign rd_ok_o      = rw_ready & {NUM_BANKS{wtr_zero}};
  assign wr_ok_o      = rw_ready;
  assign pre_ok_o     = pre_ready;
  assign pre_all_ok_o = &all_ready;
  assign ref_ok_o     = (&act_ready) && rfc_zero;
  assign row_warn_o   = |warn;

  always_comb begin
    case (kind)
      CMD_ACT: legal = act_ok_o[cmd_bank];
      CMD_RD:  legal = rd_ok_o[cmd_bank];
      CMD_WR:  legal = wr_ok_o[cmd_bank];
      CMD_PRE: legal = cmd_a10 ? pre_all_ok_o : pre_ok_o[cmd_bank];
      CMD_REF: legal = ref_ok_o;
      default: legal = 1'b0;
    endcase
  end

  assign accept   = cmd_issue && legal;
  assign ref_fire = accept && (kind == CMD_REF);

  always_comb begin
    act_fire = '0;
    rd_fire  = '0;
    wr_fire  = '0;
    pre_fire = '0;
    if (accept) begin
      case (kind)
        CMD_ACT: act_fire = sel;
        CMD_RD:  rd_fire  = sel;
        CMD_WR:  wr_fire  = sel;
        CMD_PRE: pre_fire = cmd_a10 ? {NUM_BANKS{1'b1}} : sel;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dtc_bank #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
      .T_WREC(T_WREC), .T_RAS_MAX(T_RAS_MAX), .WARN_AT(WARN_AT)
    ) u_bank (
      .clk(clk), .rst_n(rst_s),
      .act_fire_i(act_fire[b]), .rd_fire_i(rd_fire[b]),
      .wr_fire_i(wr_fire[b]), .pre_fire_i(pre_fire[b]),
      .auto_close_req_i(cmd_a10),
      .open_o(bank_open_o[b]), .act_ready_o(act_ready[b]),
      .rw_ready_o(rw_ready[b]), .pre_ready_o(pre_ready[b]),
      .all_ready_o(all_ready[b]), .warn_o(warn[b])
    );
  end

  dtc_global #(.T_RRD(T_RRD), .T_WTR_TOT(T_WTR_TOT), .T_RFC(T_RFC)) u_global (
    .clk(clk), .rst_n(rst_s),
    .act_any_i(|act_fire), .wr_any_i(|wr_fire), .ref_fire_i(ref_fire),
    .rrd_zero_o(rrd_zero), .wtr_zero_o(wtr_zero), .rfc_zero_o(rfc_zero)
  );

  // R5: no bank may open in the clock after any bank opened
  p_rrd_gap_r5: assert property (@(posedge clk) disable iff (!rst_s)
    ((|act_fire) && T_RRD > 1) |=> (act_ok_o == '0));
  // R12: the age warning needs an open row
  p_warn_open_r12: assert property (@(posedge clk) disable iff (!rst_s)
    row_warn_o |-> (|bank_open_o));
  // R11: a refused command leaves the open-row state untouched
  p_refused_stable_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_issue && !legal && kind != CMD_PRE) |=> $stable(bank_open_o));
endmodule

// File: tb/dtc_timing_checker_tb.sv
module dtc_timing_checker_tb_top;
  import dtc_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       cmd_issue;
  logic [2:0] cmd_kind;
  logic [1:0] cmd_bank;
  logic       cmd_a10;
  logic [3:0] act_ok, rd_ok, wr_ok, pre_ok, bank_open;
  logic       pre_all_ok, ref_ok, row_warn;

  int checks = 0;
  int errors = 0;

  dtc_timing_checker #(.T_RAS_MAX(40), .ROW_WARN_MARGIN(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_a10(cmd_a10),
    .act_ok_o(act_ok), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .pre_ok_o(pre_ok),
    .pre_all_ok_o(pre_all_ok), .ref_ok_o(ref_ok),
    .bank_open_o(bank_open), .row_warn_o(row_warn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input cmd_e k, input logic [1:0] b, input logic a10);
    cmd_issue = 1'b1; cmd_kind = k; cmd_bank = b; cmd_a10 = a10;
    @(negedge clk);
    cmd_issue = 1'b0; cmd_kind = CMD_NONE; cmd_bank = 2'd0; cmd_a10 = 1'b0;
  endtask

  task automatic do_reset();
    cmd_issue = 1'b0; cmd_kind = CMD_NONE; cmd_bank = 2'd0; cmd_a10 = 1'b0;
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 act_ok", act_ok, 4'hF);
    chk("R1 rd_ok", rd_ok, 0);
    chk("R1 wr_ok", wr_ok, 0);
    chk("R1 pre_ok", pre_ok, 0);
    chk("R1 pre_all_ok", pre_all_ok, 1);
    chk("R1 ref_ok", ref_ok, 1);
    chk("R1 open", bank_open, 0);
    chk("R1 warn", row_warn, 0);
  endtask

  task automatic t_rcd();
    do_reset();
    issue(CMD_ACT, 2'd1, 1'b0);
    chk("R2 open", bank_open, 4'b0010);
    wait_n(2);
    chk("R2 rd early", rd_ok[1], 0);
    chk("R2 wr early", wr_ok[1], 0);
    wait_n(1);
    chk("R2 rd ready", rd_ok[1], 1);
    chk("R2 wr ready", wr_ok[1], 1);
    chk("R2 closed bank no rd", rd_ok[0], 0);
  endtask

  task automatic t_ras_rp();
    do_reset();
    issue(CMD_ACT, 2'd2, 1'b0);
    wait_n(6);
    chk("R3 pre early", pre_ok[2], 0);
    wait_n(1);
    chk("R3 pre ready", pre_ok[2], 1);
    issue(CMD_PRE, 2'd2, 1'b0);
    chk("R3 closed", bank_open, 0);
    chk("R3 pre on closed", pre_ok[2], 0);
    wait_n(2);
    chk("R4 act early", act_ok[2], 0);
    wait_n(1);
    chk("R4 act ready", act_ok[2], 1);
  endtask

  task automatic t_rrd_ignore();
    do_reset();
    issue(CMD_ACT, 2'd0, 1'b0);
    chk("R5 other bank blocked", act_ok[3], 0);
    issue(CMD_ACT, 2'd3, 1'b0);   // refused
    chk("R11 refused act", bank_open, 4'b0001);
    chk("R5 other bank ready", act_ok[3], 1);
    chk("R5 same bank open", act_ok[0], 0);
    issue(CMD_PRE, 2'd0, 1'b0);   // refused, row-active minimum not met
    chk("R11 refused pre", bank_open, 4'b0001);
  endtask

  task automatic t_write();
    do_reset();
    issue(CMD_ACT, 2'd0, 1'b0);
    wait_n(1);
    issue(CMD_ACT, 2'd1, 1'b0);
    wait_n(1);
    issue(CMD_WR, 2'd0, 1'b0);
    wait_n(3);
    chk("R7 rd other bank held", rd_ok[1], 0);
    chk("R7 rd same bank held", rd_ok[0], 0);
    wait_n(1);
    chk("R7 rd other bank ready", rd_ok[1], 1);
    chk("R7 rd same bank ready", rd_ok[0], 1);
    chk("R6 pre held", pre_ok[0], 0);
    wait_n(1);
    chk("R6 pre ready", pre_ok[0], 1);
  endtask

  task automatic t_auto_close();
    do_reset();
    issue(CMD_ACT, 2'd3, 1'b0);
    wait_n(3);
    issue(CMD_RD, 2'd3, 1'b1);
    chk("R8 rd blocked", rd_ok[3], 0);
    chk("R8 pre blocked", pre_ok[3], 0);
    chk("R8 pre_all blocked", pre_all_ok, 0);
    wait_n(3);
    chk("R8 still open", bank_open[3], 1);
    wait_n(1);
    chk("R8 closed", bank_open[3], 0);
    wait_n(2);
    chk("R8 act after close early", act_ok[3], 0);
    wait_n(1);
    chk("R8 act after close ready", act_ok[3], 1);
    // write with auto-close waits for write recovery as well
    issue(CMD_ACT, 2'd2, 1'b0);
    wait_n(3);
    issue(CMD_WR, 2'd2, 1'b1);
    wait_n(5);
    chk("R8 write close waits", bank_open[2], 1);
    wait_n(1);
    chk("R8 write close done", bank_open[2], 0);
  endtask

  task automatic t_pre_all();
    do_reset();
    issue(CMD_ACT, 2'd0, 1'b0);
    wait_n(1);
    issue(CMD_ACT, 2'd1, 1'b0);
    wait_n(6);
    chk("R9 all held", pre_all_ok, 0);
    chk("R9 single ready", pre_ok[0], 1);
    wait_n(1);
    chk("R9 all ready", pre_all_ok, 1);
    issue(CMD_PRE, 2'd0, 1'b0);
    chk("R9 single closes one", bank_open, 4'b0010);
    issue(CMD_PRE, 2'd0, 1'b1);
    chk("R9 all closes rest", bank_open, 4'b0000);
  endtask

  task automatic t_refresh();
    do_reset();
    issue(CMD_REF, 2'd0, 1'b0);
    chk("R10 ref busy", ref_ok, 0);
    chk("R10 act busy", act_ok, 0);
    wait_n(12);
    chk("R10 ref busy end", ref_ok, 0);
    wait_n(1);
    chk("R10 ref ready", ref_ok, 1);
    chk("R10 act ready", act_ok, 4'hF);
    issue(CMD_ACT, 2'd0, 1'b0);
    chk("R10 ref with open bank", ref_ok, 0);
  endtask

  task automatic t_warn();
    do_reset();
    issue(CMD_ACT, 2'd0, 1'b0);
    wait_n(31);
    chk("R12 below threshold", row_warn, 0);
    wait_n(1);
    chk("R12 at threshold", row_warn, 1);
    issue(CMD_PRE, 2'd0, 1'b0);
    chk("R12 cleared on close", row_warn, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rcd();
    t_ras_rp();
    t_rrd_ignore();
    t_write();
    t_auto_close();
    t_pre_all();
    t_refresh();
    t_warn();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule